// File: doc/BRIEF.md
# Snapshot-Latched 64-bit Free-Running Counter

This block keeps a wide up counter that advances once on every clock cycle in which the tick enable is high. The tick enable is typically pulsed at the oscillator rate. System software uses the count as a timebase and for microsecond busy-wait loops. The count is wider than the 32-bit register bus, so it cannot be read in one access. Reading the two halves of the live value in turn could therefore pair a stale half with a fresh one.

To prevent that, software asks for a snapshot first. Writing a one into the request bit of the control word sets a busy flag. A fixed number of cycles later, the block copies the whole live count into a shadow register and drops the flag. Software polls the flag until it reads zero, then fetches the upper and lower halves. Both halves come from the frozen shadow and always belong to the same instant. The live count keeps running the whole time.

Top module: `snapctr64`

## Requirements
- R1: After reset, the live count, the shadow and the busy flag are all zero, so reads of the control, low and high words all return 0.
- R2: The live count rises by exactly 1 on each rising clock edge where `tick_en` is high, holds otherwise, and wraps from all ones to zero.
- R3: A write to offset 0xA0 with bit 1 of the data set starts a snapshot when none is pending. From the next cycle on, a read of 0xA0 returns bit 1 = 1 (busy); every other bit of that word reads 0.
- R4: The busy bit clears on the LATCH_DELAY-th rising edge after the accepted write (2 by default). The shadow then holds the live count as it stood just before that edge.
- R5: A read of 0xA4 returns shadow bits 31:0 and a read of 0xA8 returns shadow bits 63:32. Both stay unchanged until the next snapshot completes, whatever the read order and however far the live count moves.
- R6: A write to 0xA0 with bit 1 clear has no effect: busy stays 0 and the shadow is unchanged.
- R7: A request written while a snapshot is pending is ignored: completion time and captured value are those of the first request.
- R8: Writes to 0xA4, 0xA8 or any unmapped offset change nothing, and reads of unmapped offsets return 0.
- R9: While the count runs without wrapping, each completed snapshot is greater than or equal to the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one pulse per oscillator tick |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the same cycle as the read strobe |

## Verification
A busy-wait counter that stalls or is off by one shows up in the very next snapshot. The captured value then differs from the number of enabled ticks since reset, and the bench counts those ticks itself. A wait counter that loads the wrong value, or is reloaded by a second request, moves the cycle in which the busy bit clears. That change is visible on the control word one cycle early or late. A shadow that is updated outside completion, or halves that are swapped or mis-decoded, appear as a mismatch on the first low or high read after the disturbing write or the extra counting.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;

    // register offsets; software depends on these
    localparam int OFS_CTRL = 'hA0;
    localparam int OFS_LO   = 'hA4;
    localparam int OFS_HI   = 'hA8;

    // position of the snapshot request / busy bit in the control word
    localparam int REQ_BIT  = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI
    } reg_sel_e;

endpackage

// File: rtl/snapctr_count.sv
module snapctr_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_en) begin
            s_d.count = s_q.count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.count;

    // R2: hold when idle, wrap from all ones
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_o));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (&count_o)) |=> (count_o == '0));

endmodule

// File: rtl/snapctr_latch.sv
module snapctr_latch #(
    parameter int CNT_W       = 64,
    parameter int LATCH_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] live_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] shadow_o
);

    localparam int WAIT_W = (LATCH_DELAY > 1) ? $clog2(LATCH_DELAY) : 1;
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(LATCH_DELAY - 1);

    typedef struct packed {
        logic              busy;
        logic [WAIT_W-1:0] wait_cnt;
        logic [CNT_W-1:0]  shadow;
    } lat_state_t;

    lat_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (req_i) begin
                s_d.busy     = 1'b1;
                s_d.wait_cnt = WAIT_LOAD;
            end
        end else if (s_q.wait_cnt == '0) begin
            s_d.shadow = live_i;
            s_d.busy   = 1'b0;
        end else begin
            s_d.wait_cnt = s_q.wait_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = s_q.busy;
    assign shadow_o = s_q.shadow;

    // R3: an accepted request raises busy
    p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o);
    // R4: completion drops busy and holds the pre-edge count
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.wait_cnt == '0) |=> (!busy_o && shadow_o == $past(live_i)));
    // R5: shadow frozen outside completion
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(shadow_o));
    // R7: a second request does not restart the wait
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.wait_cnt != '0 && req_i) |=>
            (busy_o && s_q.wait_cnt == $past(s_q.wait_cnt) - 1'b1));

endmodule

// File: rtl/snapctr_regs.sv
module snapctr_regs
    import snapctr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  shadow_i,
    output logic              req_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int WIDE_W = 2 * DATA_W;

    reg_sel_e          sel;
    logic [WIDE_W-1:0] wide;
    logic              unused_wbits;

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            sel = SEL_CTRL;
        end else if (bus_addr == ADDR_W'(OFS_LO)) begin
            sel = SEL_LO;
        end else if (bus_addr == ADDR_W'(OFS_HI)) begin
            sel = SEL_HI;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        wide              = '0;
        wide[CNT_W-1:0]   = shadow_i;
        rdata_o           = '0;
        if (bus_en && !bus_we) begin
            case (sel)
                SEL_CTRL: rdata_o[REQ_BIT] = busy_i;
                SEL_LO:   rdata_o = wide[DATA_W-1:0];
                SEL_HI:   rdata_o = wide[WIDE_W-1:DATA_W];
                default:  rdata_o = '0;
            endcase
        end
    end

    assign req_o = bus_en && bus_we && (sel == SEL_CTRL) && bus_wdata[REQ_BIT];

    assign unused_wbits = ^{bus_wdata[DATA_W-1:REQ_BIT+1], bus_wdata[REQ_BIT-1:0]};

    // R3: control read shows only the busy bit
    p_ctrl_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_CTRL)) |->
            (rdata_o == (DATA_W'(busy_i) << REQ_BIT)));
    // R6: a control write with the request bit clear issues no request
    p_zero_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && !bus_wdata[REQ_BIT]) |-> !req_o);
    // R8: unmapped reads return zero
    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr != ADDR_W'(OFS_CTRL) &&
         bus_addr != ADDR_W'(OFS_LO) && bus_addr != ADDR_W'(OFS_HI)) |-> (rdata_o == '0));

endmodule

// File: rtl/snapctr64.sv
module snapctr64 #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 64,
    parameter int LATCH_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] shadow;
    logic             busy;
    logic             req;

    snapctr_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count_o (live_cnt)
    );

    snapctr_latch #(
        .CNT_W       (CNT_W),
        .LATCH_DELAY (LATCH_DELAY)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req),
        .live_i   (live_cnt),
        .busy_o   (busy),
        .shadow_o (shadow)
    );

    snapctr_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy_i    (busy),
        .shadow_i  (shadow),
        .req_o     (req),
        .rdata_o   (bus_rdata)
    );

endmodule

// File: tb/snapctr64_bench.sv
module snapctr64_bench;

    localparam logic [7:0] A_CTRL = 8'hA0;
    localparam logic [7:0] A_LO   = 8'hA4;
    localparam logic [7:0] A_HI   = 8'hA8;
    localparam logic [7:0] A_BAD  = 8'hB0;

    // {gap cycles [9:2], tick mode [1:0]}: 0 off, 1 on, 2 alternate
    localparam int NVEC = 8;
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {8'd3, 2'd1}, {8'd0, 2'd1}, {8'd5, 2'd0}, {8'd7, 2'd2},
        {8'd1, 2'd2}, {8'd12, 2'd1}, {8'd4, 2'd0}, {8'd9, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    logic [63:0] model;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model <= '0;
        else if (tick_en) model <= model + 64'd1;
    end

    snapctr64 u_snapctr64 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called just after a negedge; returns before the next posedge
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        #1 bus_en = 1'b0;
    endtask

    // called just after a negedge; returns just after the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read64(output logic [63:0] v);
        logic [31:0] hi, lo;
        rd(A_HI, hi);
        rd(A_LO, lo);
        v = {hi, lo};
    endtask

    // full request / poll / fetch cycle with timing checks
    task automatic snap(output logic [63:0] exp);
        logic [31:0] c;
        logic [63:0] v;
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, c); chk("R3 busy after request", {32'h0, c}, 64'h2);
        @(negedge clk);
        rd(A_CTRL, c); chk("R4 busy one edge later", {32'h0, c}, 64'h2);
        exp = model;
        @(negedge clk);
        rd(A_CTRL, c); chk("R4 busy clear at second edge", {32'h0, c}, 64'h0);
        read64(v); chk("R4 R2 captured count", v, exp);
    endtask

    initial begin
        logic [31:0] c;
        logic [63:0] v, e, prev, keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_CTRL, c); chk("R1 ctrl after reset", {32'h0, c}, 64'h0);
        read64(v);     chk("R1 shadow after reset", v, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        prev = '0;

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] mode;
            mode = VEC[i][1:0];
            for (int g = 0; g < int'(VEC[i][9:2]); g++) begin
                tick_en = (mode == 2'd2) ? ~tick_en : (mode == 2'd1);
                @(negedge clk);
            end
            tick_en = (mode != 2'd0);
            snap(e);
            chk("R9 snapshot not below previous", {63'h0, e >= prev}, 64'h1);
            prev = e;
            tick_en = 1'b1;
            repeat (3) @(negedge clk);
            // R5: frozen, low word read first this time
            rd(A_LO, c); chk("R5 low frozen", {32'h0, c}, {32'h0, e[31:0]});
            rd(A_HI, c); chk("R5 high frozen", {32'h0, c}, {32'h0, e[63:32]});
        end

        // R2: counter holds while tick is low
        tick_en = 1'b0;
        snap(e);
        repeat (4) @(negedge clk);
        snap(v);
        chk("R2 hold without tick", v, e);

        // R6: write with request bit clear
        tick_en = 1'b1;
        keep = v;
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, c); chk("R6 no busy", {32'h0, c}, 64'h0);
        repeat (3) @(negedge clk);
        read64(v); chk("R6 shadow unchanged", v, keep);

        // R8: writes elsewhere ignored, unmapped read zero
        wr(A_LO, 32'hDEAD_BEEF);
        wr(A_HI, 32'hCAFE_F00D);
        wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_CTRL, c); chk("R8 no busy from other writes", {32'h0, c}, 64'h0);
        read64(v); chk("R8 shadow unchanged", v, keep);
        rd(A_BAD, c); chk("R8 unmapped read", {32'h0, c}, 64'h0);

        // R7: second request while pending
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, c); chk("R7 still busy", {32'h0, c}, 64'h2);
        e = model;
        @(negedge clk);
        rd(A_CTRL, c); chk("R7 clears on original schedule", {32'h0, c}, 64'h0);
        read64(v); chk("R7 first request value", v, e);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rd(A_CTRL, c); chk("R1 ctrl after second reset", {32'h0, c}, 64'h0);
        read64(v); chk("R1 shadow after second reset", v, 64'h0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        @(negedge clk);
        snap(e);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule